// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general and status register storage for a 32-bit RISC core whose processor mode changes which physical word stands behind some register names. The core presents a 4-bit architectural index on each of two read ports and on one write port, together with a 3-bit mode. A slot map turns each mode and index pair into one of 37 physical words. Some names land on words that every mode shares. Others land on words private to one mode.

The architectural view always holds eighteen words: sixteen general registers, the current status word and one saved status word. Index 15 is the program counter. Its value is also driven on a dedicated port so that the fetch logic can read it without using a read port. Both read ports are registered. A write and a read that hit the same physical word in the same cycle return the newly written data.

Top module: `banked_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, every physical word is cleared. After that edge `rd_a_data`, `rd_b_data`, `pc_q`, `cpsr_q` and `spsr_q` read zero.
- R2: Each read port is registered. The data for an index presented before a rising edge appears on the port after that edge, and the port holds its value until the next edge.
- R3: Indices 0 to 7 and the current status word map to the same storage in every mode. A value written in one mode reads back unchanged in any other mode.
- R4: Indices 8 to 12 share one set of words in every mode except fast-interrupt mode (code 1), which has its own private words for indices 8 to 12.
- R5: Indices 13 and 14 are private to each mode. User mode, fast-interrupt, interrupt, supervisor, abort and undefined modes each have their own pair.
- R6: Index 15 is the program counter in every mode. A write to index 15 shows on `pc_q` and on a read of index 15 one edge later.
- R7: A general write changes storage only when `wr_en` is high. It uses the slot that `mode` and `wr_idx` select in that same cycle.
- R8: When a read index resolves to the same physical word as an enabled write in the same cycle, the read port returns `wr_data` after the edge.
- R9: Modes 1 to 5 each have a private saved status word, written through `spsr_we` and read on `spsr_q` one edge later. In any other mode `spsr_q` reads zero and `spsr_we` changes no storage.
- R10: Mode codes are 0 user, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort and 5 undefined. Codes 6 and 7 use the user-mode mapping.
- R11: A `cpsr_we` write shows on `cpsr_q` after the next edge, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Current processor mode code |
| rd_a_idx | input | 4 | Architectural index for read port A |
| rd_a_data | output | 32 | Registered data of read port A |
| rd_b_idx | input | 4 | Architectural index for read port B |
| rd_b_data | output | 32 | Registered data of read port B |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | Architectural index of the write |
| wr_data | input | 32 | Write data |
| pc_q | output | 32 | Current program counter word |
| cpsr_we | input | 1 | Current status word write enable |
| cpsr_wdata | input | 32 | Current status word write data |
| cpsr_q | output | 32 | Current status word |
| spsr_we | input | 1 | Saved status word write enable for the current mode |
| spsr_wdata | input | 32 | Saved status word write data |
| spsr_q | output | 32 | Registered saved status word of the current mode |

## Verification
Properties that hold on every cycle are checked by assertions: reset clearing, write-then-read bypass on both ports, the program counter and current status update one edge after a write, and a stable program counter and status word when no write is enabled. The zero saved status in user and unused modes is also checked this way. Aliasing between modes cannot be seen in one cycle. Private and shared words are shown only by bench scenarios that write in one mode and read back in another: fast-interrupt high registers, per-mode stack and link pairs, and mode codes 6 and 7 falling back to user storage.

// File: rtl/bkrf_pkg.sv
package bkrf_pkg;

  localparam int PHYS_REGS   = 37;
  localparam int SLOT_W      = 6;
  localparam int SLOT_PC     = 15;
  localparam int SLOT_CPSR   = 16;
  localparam int FIQ_BASE    = 17;   // fast-interrupt r8..r14
  localparam int FIQ_SPSR    = 24;
  localparam int PRIV_BASE   = 25;   // irq, svc, abt, und: r13, r14, saved status
  localparam int PRIV_STRIDE = 3;

  localparam logic [2:0] MODE_USR = 3'd0;
  localparam logic [2:0] MODE_FIQ = 3'd1;
  localparam logic [2:0] MODE_IRQ = 3'd2;
  localparam logic [2:0] MODE_UND = 3'd5;

  function automatic logic is_priv_small(input logic [2:0] m);
    return (m >= MODE_IRQ) && (m <= MODE_UND);
  endfunction

  function automatic logic [SLOT_W-1:0] priv_base(input logic [2:0] m);
    return SLOT_W'(PRIV_BASE) + SLOT_W'(PRIV_STRIDE) * SLOT_W'(m - MODE_IRQ);
  endfunction

  function automatic logic [SLOT_W-1:0] gpr_slot(input logic [2:0] m, input logic [3:0] idx);
    logic [SLOT_W-1:0] ix;
    ix = SLOT_W'(idx);
    if (idx == 4'd15)                 return SLOT_W'(SLOT_PC);
    else if (idx < 4'd8)              return ix;
    else if (m == MODE_FIQ)           return SLOT_W'(FIQ_BASE) + ix - SLOT_W'(8);
    else if (idx < 4'd13)             return ix;
    else if (is_priv_small(m))        return priv_base(m) + ix - SLOT_W'(13);
    else                              return ix;
  endfunction

  function automatic logic spsr_present(input logic [2:0] m);
    return (m == MODE_FIQ) || is_priv_small(m);
  endfunction

  function automatic logic [SLOT_W-1:0] spsr_slot(input logic [2:0] m);
    if (m == MODE_FIQ)         return SLOT_W'(FIQ_SPSR);
    else if (is_priv_small(m)) return priv_base(m) + SLOT_W'(2);
    else                       return '0;
  endfunction

endpackage

// File: rtl/bkrf_slot_map.sv
module bkrf_slot_map
  import bkrf_pkg::*;
(
  input  logic [2:0]        mode,
  input  logic [3:0]        idx,
  output logic [SLOT_W-1:0] slot
);
  always_comb slot = gpr_slot(mode, idx);
endmodule

// File: rtl/bkrf_read_port.sv
module bkrf_read_port
  import bkrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NSLOTS = PHYS_REGS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic [3:0]        idx,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] regs [NSLOTS],
  output logic [DATA_W-1:0] q
);
  logic [SLOT_W-1:0] rslot;

  bkrf_slot_map u_map (.mode(mode), .idx(idx), .slot(rslot));

  always_ff @(posedge clk) begin
    if (rst)                            q <= '0;
    else if (wr_en && wr_slot == rslot) q <= wr_data;
    else                                q <= regs[rslot];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bkrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] pc_q,
  input  logic              cpsr_we,
  input  logic [DATA_W-1:0] cpsr_wdata,
  output logic [DATA_W-1:0] cpsr_q,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wdata,
  output logic [DATA_W-1:0] spsr_q
);
  localparam int RD_PORTS = 2;

  logic [DATA_W-1:0] regs [PHYS_REGS];
  logic [SLOT_W-1:0] wslot;
  logic [SLOT_W-1:0] sslot;
  logic              s_ok;
  logic [3:0]        rd_idx [RD_PORTS];
  logic [DATA_W-1:0] rd_q   [RD_PORTS];

  bkrf_slot_map u_wmap (.mode(mode), .idx(wr_idx), .slot(wslot));

  always_comb begin
    sslot = spsr_slot(mode);
    s_ok  = spsr_present(mode);
  end

  // Physical storage: every slot is distinct, so the three writers never collide
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHYS_REGS; i++) regs[i] <= '0;
    end else begin
      if (wr_en)          regs[wslot]     <= wr_data;
      if (cpsr_we)        regs[SLOT_CPSR] <= cpsr_wdata;
      if (spsr_we && s_ok) regs[sslot]    <= spsr_wdata;
    end
  end

  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;

  for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
    bkrf_read_port #(.DATA_W(DATA_W), .NSLOTS(PHYS_REGS)) u_rd (
      .clk(clk), .rst(rst), .mode(mode), .idx(rd_idx[g]),
      .wr_en(wr_en), .wr_slot(wslot), .wr_data(wr_data),
      .regs(regs), .q(rd_q[g])
    );
  end

  assign rd_a_data = rd_q[0];
  assign rd_b_data = rd_q[1];
  assign pc_q      = regs[SLOT_PC];
  assign cpsr_q    = regs[SLOT_CPSR];

  always_ff @(posedge clk) begin
    if (rst || !s_ok)  spsr_q <= '0;
    else if (spsr_we)  spsr_q <= spsr_wdata;
    else               spsr_q <= regs[sslot];
  end
endmodule

// File: rtl/bkrf_chk.sv
module bkrf_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        mode,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [3:0]        rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] pc_q,
  input logic              cpsr_we,
  input logic [DATA_W-1:0] cpsr_wdata,
  input logic [DATA_W-1:0] cpsr_q,
  input logic [DATA_W-1:0] spsr_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rd_a_data == '0 && rd_b_data == '0 && pc_q == '0 && cpsr_q == '0 && spsr_q == '0));

  // R8
  bypass_a_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == rd_a_idx) |=> rd_a_data == $past(wr_data));

  // R8
  bypass_b_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == rd_b_idx) |=> rd_b_data == $past(wr_data));

  // R6
  pc_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 4'd15) |=> pc_q == $past(wr_data));

  // R7
  no_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !cpsr_we) |=> ($stable(pc_q) && $stable(cpsr_q)));

  // R11
  cpsr_write_chk: assert property (@(posedge clk) disable iff (rst)
    cpsr_we |=> cpsr_q == $past(cpsr_wdata));

  // R9
  spsr_absent_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 || mode > 3'd5) |=> spsr_q == '0);
endmodule

bind banked_regfile bkrf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .pc_q(pc_q), .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata),
  .cpsr_q(cpsr_q), .spsr_q(spsr_q)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  mode;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, pc_q;
  logic        wr_en, cpsr_we, spsr_we;
  logic [31:0] cpsr_wdata, cpsr_q, spsr_wdata, spsr_q;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst(rst), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .pc_q(pc_q),
    .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata), .cpsr_q(cpsr_q),
    .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_q(spsr_q)
  );

  // {mode, wr_en, wr_idx, wr_data, rd_a_idx, expected rd_a_data}
  localparam int NV = 19;
  localparam logic [75:0] VEC [NV] = '{
    {3'd0, 1'b1, 4'd0,  32'h0000_00A0, 4'd0,  32'h0000_00A0}, // R8 bypass
    {3'd1, 1'b0, 4'd0,  32'h0,         4'd0,  32'h0000_00A0}, // R3 shared low
    {3'd0, 1'b1, 4'd8,  32'h0000_0088, 4'd8,  32'h0000_0088}, // R8
    {3'd1, 1'b1, 4'd8,  32'h0000_00F8, 4'd8,  32'h0000_00F8}, // R4 fiq r8
    {3'd0, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0000_0088}, // R4 user r8 kept
    {3'd2, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0000_0088}, // R4 irq shares r8
    {3'd0, 1'b1, 4'd13, 32'h0000_1300, 4'd13, 32'h0000_1300}, // R5
    {3'd2, 1'b1, 4'd13, 32'h0000_2213, 4'd13, 32'h0000_2213}, // R5
    {3'd3, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0000_0000}, // R5 svc private
    {3'd0, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0000_1300}, // R5 user kept
    {3'd6, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0000_1300}, // R10 code 6 = user
    {3'd2, 1'b0, 4'd14, 32'hDEAD_BEEF, 4'd14, 32'h0000_0000}, // R7 gated
    {3'd3, 1'b1, 4'd15, 32'h0000_0100, 4'd15, 32'h0000_0100}, // R6
    {3'd1, 1'b0, 4'd0,  32'h0,         4'd15, 32'h0000_0100}, // R6 pc in fiq
    {3'd5, 1'b1, 4'd14, 32'h0000_005E, 4'd0,  32'h0000_00A0}, // R7 write, R3 read
    {3'd5, 1'b0, 4'd0,  32'h0,         4'd14, 32'h0000_005E}, // R5 und r14
    {3'd4, 1'b0, 4'd0,  32'h0,         4'd14, 32'h0000_0000}, // R5 abt r14
    {3'd1, 1'b1, 4'd12, 32'h0000_0F12, 4'd12, 32'h0000_0F12}, // R4
    {3'd3, 1'b0, 4'd0,  32'h0,         4'd12, 32'h0000_0000}  // R4 non-fiq r12
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; cpsr_we = 1'b0; spsr_we = 1'b0;
    wr_idx = '0; wr_data = '0; cpsr_wdata = '0; spsr_wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; mode = 3'd0; rd_a_idx = '0; rd_b_idx = '0;
    idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    check("R1 rd_a reset", rd_a_data, 32'h0);
    check("R1 pc reset", pc_q, 32'h0);
    check("R1 cpsr reset", cpsr_q, 32'h0);
    check("R1 spsr reset", spsr_q, 32'h0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode = VEC[i][75:73]; wr_en = VEC[i][72]; wr_idx = VEC[i][71:68];
      wr_data = VEC[i][67:36]; rd_a_idx = VEC[i][35:32];
      tick();
      check($sformatf("vector %0d rd_a (R3/R4/R5/R6/R7/R8/R10)", i), rd_a_data, VEC[i][31:0]);
    end
    check("R6 pc port", pc_q, 32'h0000_0100);

    // R2: output holds until edge
    @(negedge clk); idle_inputs(); mode = 3'd0; rd_a_idx = 4'd8;
    #1 check("R2 holds before edge", rd_a_data, 32'h0);
    tick();
    check("R2 after edge", rd_a_data, 32'h0000_0088);

    // Port B bypass and separate read (R8, R3)
    @(negedge clk); wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h0000_0033; rd_b_idx = 4'd3;
    tick();
    check("R8 port B bypass", rd_b_data, 32'h0000_0033);
    @(negedge clk); idle_inputs(); mode = 3'd4; rd_b_idx = 4'd0;
    tick();
    check("R3 port B r0 in abt", rd_b_data, 32'h0000_00A0);

    // Saved status (R9)
    @(negedge clk); mode = 3'd0; spsr_we = 1'b1; spsr_wdata = 32'h55;
    tick();
    check("R9 user spsr zero", spsr_q, 32'h0);
    @(negedge clk); mode = 3'd2; spsr_wdata = 32'h22;
    tick();
    check("R9 irq spsr write", spsr_q, 32'h22);
    @(negedge clk); mode = 3'd3; spsr_wdata = 32'h33;
    tick();
    check("R9 svc spsr write", spsr_q, 32'h33);
    @(negedge clk); mode = 3'd1; spsr_we = 1'b0;
    tick();
    check("R9 fiq spsr untouched", spsr_q, 32'h0);
    @(negedge clk); mode = 3'd2;
    tick();
    check("R9 irq spsr private", spsr_q, 32'h22);
    @(negedge clk); mode = 3'd7;
    tick();
    check("R9 code 7 spsr zero (R10)", spsr_q, 32'h0);

    // Current status shared (R11, R3)
    @(negedge clk); mode = 3'd2; cpsr_we = 1'b1; cpsr_wdata = 32'hC1;
    tick();
    check("R11 cpsr write", cpsr_q, 32'hC1);
    @(negedge clk); idle_inputs(); mode = 3'd0;
    tick();
    check("R3 cpsr shared", cpsr_q, 32'hC1);

    // Reset again clears banked storage (R1)
    @(negedge clk); rst = 1'b1;
    tick();
    @(negedge clk); rst = 1'b0; mode = 3'd1; rd_a_idx = 4'd8; rd_b_idx = 4'd15;
    tick();
    check("R1 fiq r8 cleared", rd_a_data, 32'h0);
    check("R1 pc cleared", rd_b_data, 32'h0);
    check("R1 cpsr cleared", cpsr_q, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule